// File: doc/BRIEF.md
# Two-Bank Transmit Byte Buffer with Commit and Replay

This block sits between a CPU byte-write port and an outgoing packet sender. It holds two byte banks of `DEPTH` entries each. The CPU fills the bank that is currently free, one byte per cycle, and then hands it over by writing a byte count. That write commits the bank for sending. Committed banks go to the sender in the order they were committed. The sender reads bytes only after it gives a start pulse. It finishes each attempt with a done pulse that carries a success bit.

A `buf_avail` flag tells the CPU when it may load again. Only an accepted count write lowers the flag. If the other bank is still free, the flag comes back one cycle later. When both banks are committed, the flag stays low until a send completes successfully and frees a bank.

A failed attempt keeps its bank and rewinds the read position to the first byte. The sender can then replay the same data without the CPU loading it again. A count of zero is a valid commit. It closes a transfer whose last packet filled a whole bank.

Top module: `txb_pingpong`

## Requirements
- R1: After reset both banks are free, `buf_avail` is 1, `overflow` is 0 and `snd_pending` is 0.
- R2: Bytes written with `cpu_byte_we` are read back by the sender in write order. Each `snd_rd_en` in an active send presents the next byte on `snd_rd_data` in the cycle after the request.
- R3: An accepted count write drives `buf_avail` to 0 in the next cycle. When the other bank is free, `buf_avail` returns to 1 one cycle after that.
- R4: With both banks committed, `buf_avail` stays 0 until `snd_done` with `snd_ok`=1. It then reads 1 two cycles after the done pulse.
- R5: `buf_avail` never falls except in the cycle after an accepted count write.
- R6: `snd_done` with `snd_ok`=0 keeps the bank committed (`snd_pending` stays 1, `snd_len` is unchanged). A new `snd_start` then replays the same bytes from the first one.
- R7: A count of 0 is accepted. It commits an empty bank that shows `snd_pending`=1 and `snd_len`=0.
- R8: Committed banks reach the sender in commit order. After a successful done, `snd_len` shows the count of the next committed bank.
- R9: Byte writes are ignored when the load bank is committed or already holds `DEPTH` bytes. Count writes are ignored when no bank is free or the count exceeds `DEPTH`. Each such attempt sets the sticky `overflow` flag, which only reset clears.
- R10: `snd_start` and `snd_rd_en` have no effect while nothing is pending. A later send still begins at the bank's first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_byte_we | input | 1 | Write one byte into the load bank |
| cpu_byte | input | 8 | Byte to write |
| cpu_count_we | input | 1 | Commit the load bank with a count |
| cpu_count | input | 7 | Number of valid bytes, 0 to DEPTH |
| buf_avail | output | 1 | A bank is free for loading |
| overflow | output | 1 | Sticky flag for a rejected write |
| snd_start | input | 1 | Begin sending the oldest committed bank |
| snd_rd_en | input | 1 | Request the next byte |
| snd_rd_data | output | 8 | Byte data, valid the cycle after `snd_rd_en` |
| snd_done | input | 1 | End of the current attempt |
| snd_ok | input | 1 | The attempt succeeded (qualifies `snd_done`) |
| snd_pending | output | 1 | The oldest bank is committed |
| snd_len | output | 7 | Byte count of the oldest committed bank |

## Verification
The first bank holds a short ramp and the second a full `DEPTH`-byte pattern. Because the patterns differ, a bank-select or pointer mix-up shows up at once in the scoreboard.

A failed attempt followed by a replay separates a rewind from a pointer that keeps running or a bank freed too early. A zero-length commit and a 65-byte write burst probe both edges of the count range. Stray start and read pulses on an empty buffer, followed by a fresh two-byte send, show whether the read pointer moved while nothing was pending.

// File: rtl/txb_pkg.sv
package txb_pkg;
  // Identifies one of the two storage banks
  typedef enum logic [0:0] {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_id_e;

  localparam int unsigned TXB_NUM_BANKS = 2;

  function automatic bank_id_e txb_other(input bank_id_e b);
    return bank_id_e'(~b);
  endfunction
endpackage

// File: rtl/txb_ram.sv
// Simple dual-port storage, one write port, one registered read port
module txb_ram #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txb_bank_state.sv
// Load side: bank ownership, counts, availability and overflow
module txb_bank_state
  import txb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_we,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_val,
  input  logic          free_pulse,
  output logic          ram_we,
  output logic [AW:0]   ram_waddr,
  output bank_id_e      send_sel,
  output logic          pending,
  output logic [CW-1:0] head_len,
  output logic          avail,
  output logic          ovf
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [TXB_NUM_BANKS-1:0] full_q;
  logic [CW-1:0]            len_q [TXB_NUM_BANKS];
  bank_id_e                 load_sel_q, send_sel_q;
  logic [CW-1:0]            wr_cnt_q;
  logic                     avail_q, ovf_q;

  logic load_free, byte_ok, cnt_ok, any_free, reject;

  assign load_free = !full_q[load_sel_q];
  assign byte_ok   = byte_we && load_free && (wr_cnt_q < DEPTH_C);
  assign cnt_ok    = cnt_we && load_free && (cnt_val <= DEPTH_C);
  assign reject    = (byte_we && !byte_ok) || (cnt_we && !cnt_ok);
  assign any_free  = ~&full_q;

  // Per-bank ownership and length registers
  for (genvar b = 0; b < TXB_NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        full_q[b] <= 1'b0;
        len_q[b]  <= '0;
      end else if (free_pulse && send_sel_q == bank_id_e'(b)) begin
        full_q[b] <= 1'b0;
      end else if (cnt_ok && load_sel_q == bank_id_e'(b)) begin
        full_q[b] <= 1'b1;
        len_q[b]  <= cnt_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_sel_q <= BANK_LO;
      send_sel_q <= BANK_LO;
      wr_cnt_q   <= '0;
      avail_q    <= 1'b1;
      ovf_q      <= 1'b0;
    end else begin
      if (cnt_ok) begin
        load_sel_q <= txb_other(load_sel_q);
        wr_cnt_q   <= '0;
      end else if (byte_ok) begin
        wr_cnt_q <= wr_cnt_q + 1'b1;
      end
      if (free_pulse) send_sel_q <= txb_other(send_sel_q);
      // commit drops the flag; any free bank raises it on the next cycle
      if (cnt_ok)        avail_q <= 1'b0;
      else if (any_free) avail_q <= 1'b1;
      if (reject) ovf_q <= 1'b1;
    end
  end

  assign ram_we    = byte_ok;
  assign ram_waddr = {load_sel_q, wr_cnt_q[AW-1:0]};
  assign send_sel  = send_sel_q;
  assign pending   = full_q[send_sel_q];
  assign head_len  = len_q[send_sel_q];
  assign avail     = avail_q;
  assign ovf       = ovf_q;

  // R3: an accepted commit lowers the flag on the next cycle
  a_r3_commit_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt_ok)) |-> !avail_q);

  // R5: nothing but a commit lowers the flag
  a_r5_only_commit_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(avail_q) && !$past(cnt_ok)) |-> avail_q);

  // R9: overflow is sticky until reset
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ovf_q)) |-> ovf_q);

  // R8: with both banks full the oldest is the next one to be loaded
  a_r8_commit_order: assert property (@(posedge clk) disable iff (rst)
    (&full_q) |-> (load_sel_q == send_sel_q));
endmodule

// File: rtl/txb_reader.sv
// Send side: start, sequential reads, completion and rewind
module txb_reader
  import txb_pkg::*;
#(
  parameter int CW = 7,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          rd_en,
  input  logic          done,
  input  logic          ok,
  input  logic          pending,
  input  logic [CW-1:0] head_len,
  input  bank_id_e      send_sel,
  output logic          ram_re,
  output logic [AW:0]   ram_raddr,
  output logic          free_pulse
);
  logic          active_q;
  logic [CW-1:0] ptr_q;
  logic          can_start, rd_ok, finish;

  assign can_start  = start && pending && !active_q;
  assign rd_ok      = rd_en && active_q && (ptr_q < head_len);
  assign finish     = done && active_q;
  assign free_pulse = finish && ok;
  assign ram_re     = rd_ok;
  assign ram_raddr  = {send_sel, ptr_q[AW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else if (can_start) begin
      active_q <= 1'b1;
      ptr_q    <= '0;
    end else if (finish) begin
      // success moves to the next bank, failure replays this one; both rewind
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else if (rd_ok) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  // R10: no send begins while nothing is pending
  a_r10_idle_start: assert property (@(posedge clk) disable iff (rst)
    (!pending && !active_q) |=> !active_q);

  // R2: reads never run past the committed length
  a_r2_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (ptr_q <= head_len));

  // R6: a failed attempt keeps the bank and rewinds to its first byte
  a_r6_replay_rewind: assert property (@(posedge clk) disable iff (rst)
    (finish && !ok) |=> (pending && ptr_q == '0 && !active_q));
endmodule

// File: rtl/txb_pingpong.sv
module txb_pingpong
  import txb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_byte_we,
  input  logic [DW-1:0]              cpu_byte,
  input  logic                       cpu_count_we,
  input  logic [$clog2(DEPTH+1)-1:0] cpu_count,
  output logic                       buf_avail,
  output logic                       overflow,
  input  logic                       snd_start,
  input  logic                       snd_rd_en,
  output logic [DW-1:0]              snd_rd_data,
  input  logic                       snd_done,
  input  logic                       snd_ok,
  output logic                       snd_pending,
  output logic [$clog2(DEPTH+1)-1:0] snd_len
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic          ram_we, ram_re, free_pulse, pending;
  logic [AW:0]   ram_waddr, ram_raddr;
  logic [CW-1:0] head_len;
  bank_id_e      send_sel;

  txb_bank_state #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_state (
    .clk        (clk),
    .rst        (rst),
    .byte_we    (cpu_byte_we),
    .cnt_we     (cpu_count_we),
    .cnt_val    (cpu_count),
    .free_pulse (free_pulse),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .send_sel   (send_sel),
    .pending    (pending),
    .head_len   (head_len),
    .avail      (buf_avail),
    .ovf        (overflow)
  );

  txb_reader #(.CW(CW), .AW(AW)) u_reader (
    .clk        (clk),
    .rst        (rst),
    .start      (snd_start),
    .rd_en      (snd_rd_en),
    .done       (snd_done),
    .ok         (snd_ok),
    .pending    (pending),
    .head_len   (head_len),
    .send_sel   (send_sel),
    .ram_re     (ram_re),
    .ram_raddr  (ram_raddr),
    .free_pulse (free_pulse)
  );

  txb_ram #(.DW(DW), .AW(AW + 1)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (cpu_byte),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (snd_rd_data)
  );

  assign snd_pending = pending;
  assign snd_len     = head_len;
endmodule

// File: tb/txb_pingpong_tb_top.sv
`timescale 1ns/100ps
module txb_pingpong_tb_top;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_byte_we = 1'b0;
  logic [7:0] cpu_byte = '0;
  logic       cpu_count_we = 1'b0;
  logic [6:0] cpu_count = '0;
  logic       buf_avail, overflow, snd_pending;
  logic       snd_start = 1'b0, snd_rd_en = 1'b0, snd_done = 1'b0, snd_ok = 1'b0;
  logic [7:0] snd_rd_data;
  logic [6:0] snd_len;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      exp_tag = "R2";
  logic       rd_en_d = 1'b0;

  logic [7:0] model_data [2][DEPTH];
  int         model_len [2];
  int         mh = 0;
  int         mt = 0;

  always #2.5 clk = ~clk;

  txb_pingpong #(.DW(8), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_byte_we(cpu_byte_we), .cpu_byte(cpu_byte),
    .cpu_count_we(cpu_count_we), .cpu_count(cpu_count),
    .buf_avail(buf_avail), .overflow(overflow),
    .snd_start(snd_start), .snd_rd_en(snd_rd_en), .snd_rd_data(snd_rd_data),
    .snd_done(snd_done), .snd_ok(snd_ok),
    .snd_pending(snd_pending), .snd_len(snd_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Monitor: registered read data appears the cycle after a request
  always @(posedge clk) rd_en_d <= snd_rd_en;

  always @(negedge clk) begin
    if (rd_en_d && exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      checks++;
      if (snd_rd_data !== e) begin
        errors++;
        $display("FAIL %s: actual=%0d expected=%0d", exp_tag, snd_rd_data, e);
      end
    end
  end

  // Driver: load bytes into the model and the design
  task automatic load_bytes(input int n, input int base, input int step);
    for (int i = 0; i < n; i++) begin
      cpu_byte_we = 1'b1;
      cpu_byte    = 8'(base + i * step);
      model_data[mt][i] = 8'(base + i * step);
      cyc();
    end
    cpu_byte_we = 1'b0;
  endtask

  // Commit; returns after the cycle in which the commit took effect
  task automatic commit(input int n);
    cpu_count_we = 1'b1;
    cpu_count    = 7'(n);
    cyc();
    cpu_count_we = 1'b0;
    model_len[mt] = n;
    mt ^= 1;
  endtask

  task automatic start_and_read(input string tag);
    exp_tag = tag;
    for (int i = 0; i < model_len[mh]; i++) exp_q.push_back(model_data[mh][i]);
    snd_start = 1'b1;
    cyc();
    snd_start = 1'b0;
    for (int i = 0; i < model_len[mh]; i++) begin
      snd_rd_en = 1'b1;
      cyc();
    end
    snd_rd_en = 1'b0;
    cyc();
    chk({tag, " all bytes seen"}, exp_q.size(), 0);
  endtask

  task automatic finish_send(input logic ok);
    snd_done = 1'b1;
    snd_ok   = ok;
    cyc();
    snd_done = 1'b0;
    snd_ok   = 1'b0;
    if (ok) mh ^= 1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    mh = 0;
    mt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 avail", buf_avail, 1);
    chk("R1 overflow", overflow, 0);
    chk("R1 pending", snd_pending, 0);

    // First bank: short ramp
    load_bytes(5, 8'h10, 1);
    commit(5);
    chk("R3 avail drops", buf_avail, 0);
    cyc();
    chk("R3 avail returns", buf_avail, 1);
    chk("R7 pending after commit", snd_pending, 1);
    chk("R8 head len", snd_len, 5);

    // Second bank: full pattern
    load_bytes(DEPTH, 8'h03, 7);
    commit(DEPTH);
    chk("R3 avail drops again", buf_avail, 0);
    cyc();
    chk("R4 avail stays low with both full", buf_avail, 0);

    // R9 writes with no free bank
    cpu_byte_we = 1'b1; cpu_byte = 8'hEE;
    cyc();
    cpu_byte_we = 1'b0;
    chk("R9 overflow on byte write", overflow, 1);
    cpu_count_we = 1'b1; cpu_count = 7'd3;
    cyc();
    cpu_count_we = 1'b0;
    chk("R9 head len unchanged", snd_len, 5);
    chk("R4 avail still low", buf_avail, 0);

    // R6 failed attempt then replay
    start_and_read("R2");
    finish_send(1'b0);
    chk("R6 pending kept", snd_pending, 1);
    chk("R6 len kept", snd_len, 5);
    chk("R4 avail low after fail", buf_avail, 0);
    start_and_read("R6");
    finish_send(1'b1);
    chk("R4 avail one cycle after ok", buf_avail, 0);
    cyc();
    chk("R4 avail two cycles after ok", buf_avail, 1);
    chk("R8 next head len", snd_len, DEPTH);

    // R7 zero-length commit behind the full bank
    commit(0);
    chk("R3 avail drops on zero commit", buf_avail, 0);
    cyc();
    chk("R4 avail low, both committed", buf_avail, 0);
    start_and_read("R8");
    finish_send(1'b1);
    cyc();
    chk("R7 empty bank pending", snd_pending, 1);
    chk("R7 empty bank len", snd_len, 0);
    start_and_read("R7");
    finish_send(1'b1);
    cyc();
    chk("R7 drained", snd_pending, 0);
    chk("R7 avail", buf_avail, 1);

    // R10 stray controls while empty
    snd_start = 1'b1; cyc(); snd_start = 1'b0;
    snd_rd_en = 1'b1; repeat (3) cyc(); snd_rd_en = 1'b0;
    cyc();
    chk("R10 no pending after stray start", snd_pending, 0);
    load_bytes(2, 8'hA1, 1);
    commit(2);
    cyc();
    start_and_read("R10");
    finish_send(1'b1);
    repeat (2) cyc();
    chk("R10 avail after send", buf_avail, 1);

    // Second phase: byte count limit
    do_reset();
    chk("R1 overflow cleared by reset", overflow, 0);
    load_bytes(DEPTH, 8'h40, 3);
    chk("R9 no overflow at DEPTH bytes", overflow, 0);
    cpu_byte_we = 1'b1; cpu_byte = 8'h5A;
    cyc();
    cpu_byte_we = 1'b0;
    chk("R9 overflow on extra byte", overflow, 1);
    cpu_count_we = 1'b1; cpu_count = 7'(DEPTH + 1);
    cyc();
    cpu_count_we = 1'b0;
    chk("R9 oversize count rejected", snd_pending, 0);
    commit(DEPTH);
    cyc();
    start_and_read("R9");
    finish_send(1'b1);
    cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule